// File: doc/BRIEF.md
# Neighbour-Suppression Ghost Filter

A single particle crossing overlapping detector regions is often reported by several adjacent pattern finders at once. This filter receives a full grid of muon candidates, one cell per tower (pseudorapidity row) and logic segment (azimuth column). It removes the duplicates by keeping, in each neighbourhood, only the candidate with the best rank. Each cell holds a valid bit, a 2-bit quality and a momentum code.

Suppression runs in two ordered passes. The first pass compares neighbouring segments inside each tower. The second pass compares neighbouring towers inside each segment, and only the candidates that survived the first pass take part in it. The four best remaining candidates are then reported in rank order, each with its tower and segment coordinates. Candidates that were suppressed but sit on the rim of the covered grid are reported in a separate per-cell mask. A downstream stage that sees the neighbouring grids can then settle them.

A new grid may be presented on every clock. Its result appears on the registered outputs two clock edges later.

Top module: `gf_ghost_filter`

## Requirements
- R1: While reset is asserted, every output is zero: all slot valid bits, all slot fields and the rim mask.
- R2: A valid cell is suppressed in the first pass if a valid cell at segment ±1 in the same tower has a higher quality.
- R3: If two adjacent valid cells have equal quality, the one with the larger momentum code survives.
- R4: If two adjacent valid cells tie in both quality and momentum code, the one with the lower flat index (tower × NSEG + segment) survives.
- R5: The second pass compares a first-pass survivor only with first-pass survivors at tower ±1 in the same segment. A cell removed in the first pass suppresses nothing in the second pass.
- R6: Adjacency does not wrap around: segment 0 and segment NSEG−1 are not neighbours, and neither are the first and last tower.
- R7: Output slot 0 holds the best surviving candidate and later slots hold weaker ones, ranked by quality, then momentum code, then lower flat index. Each slot carries its quality, momentum code, tower and segment. Tower occupies best_twr_o bits [k*TW +: TW] and the others are packed the same way.
- R8: When fewer than NOUT candidates survive, the filled slots are the lowest ones. Every unused slot has valid 0 and all of its fields 0.
- R9: Bit c of edge_ghost_o is 1 exactly when cell c is valid, was suppressed in either pass, and lies on the rim (segment 0, segment NSEG−1, the first tower or the last tower). Suppressed interior cells never set their bit.
- R10: A grid applied before clock edge k is reflected on all outputs just after edge k+1. Just after edge k, the outputs still show the previous grid.
- R11: A cell whose valid bit is 0 suppresses nothing, whatever its quality and momentum code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_vld_i | input | NTWR*NSEG | Per-cell valid, bit c = tower*NSEG+segment |
| cand_q_i | input | NTWR*NSEG*QW | Per-cell quality, field c at [c*QW +: QW] |
| cand_pt_i | input | NTWR*NSEG*PW | Per-cell momentum code, field c at [c*PW +: PW] |
| best_vld_o | output | NOUT | Slot valid, bit 0 is the best slot |
| best_q_o | output | NOUT*QW | Slot quality |
| best_pt_o | output | NOUT*PW | Slot momentum code |
| best_twr_o | output | NOUT*TW | Slot tower index |
| best_seg_o | output | NOUT*SW | Slot segment index |
| edge_ghost_o | output | NTWR*NSEG | Suppressed rim cells, one bit per cell |

## Verification
The bench builds the filter with its defaults: 12 segments, 4 towers, 2-bit quality, 5-bit momentum code and four output slots. With four towers there are two interior tower rows, so rim and interior suppression can both be observed. The bench sweeps every quality pair over several momentum codes for one neighbour pair in each direction, which covers every rank ordering and every tie case. It then runs hundreds of random grids of varying density and compares them against a model that ranks survivors by counting. Directed grids target the pass order, the absence of wrap-around, invalid cells that carry a high rank, and the two-edge latency.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int KW = 16;
  typedef logic [KW-1:0] rank_key_t;

  // Quality occupies the upper byte so it dominates the momentum code.
  function automatic rank_key_t make_key(logic [7:0] q, logic [7:0] pt);
    return {q, pt};
  endfunction

  // True when candidate a ranks strictly above candidate b.
  function automatic logic outranks(rank_key_t ka, int ia, rank_key_t kb, int ib);
    return (ka > kb) || ((ka == kb) && (ia < ib));
  endfunction
endpackage

// File: rtl/gf_phi_stage.sv
module gf_phi_stage #(
  parameter int NSEG = 12,
  parameter int NTWR = 4,
  localparam int NCELL = NSEG * NTWR
) (
  input  logic                      vld_i   [NCELL],
  input  gf_pkg::rank_key_t         key_i   [NCELL],
  output logic                      ghost_o [NCELL]
);
  for (genvar t = 0; t < NTWR; t++) begin : g_twr
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam int C = t * NSEG + s;
      logic beat_lo, beat_hi;
      if (s > 0) begin : g_lo
        assign beat_lo = vld_i[C-1] && gf_pkg::outranks(key_i[C-1], C - 1, key_i[C], C);
      end else begin : g_nlo
        assign beat_lo = 1'b0;
      end
      if (s < NSEG - 1) begin : g_hi
        assign beat_hi = vld_i[C+1] && gf_pkg::outranks(key_i[C+1], C + 1, key_i[C], C);
      end else begin : g_nhi
        assign beat_hi = 1'b0;
      end
      assign ghost_o[C] = vld_i[C] && (beat_lo || beat_hi);
    end
  end
endmodule

// File: rtl/gf_eta_stage.sv
module gf_eta_stage #(
  parameter int NSEG = 12,
  parameter int NTWR = 4,
  localparam int NCELL = NSEG * NTWR
) (
  input  logic                      live_i  [NCELL],
  input  gf_pkg::rank_key_t         key_i   [NCELL],
  output logic                      ghost_o [NCELL]
);
  for (genvar t = 0; t < NTWR; t++) begin : g_twr
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam int C = t * NSEG + s;
      logic beat_dn, beat_up;
      if (t > 0) begin : g_dn
        assign beat_dn = live_i[C-NSEG] && gf_pkg::outranks(key_i[C-NSEG], C - NSEG, key_i[C], C);
      end else begin : g_ndn
        assign beat_dn = 1'b0;
      end
      if (t < NTWR - 1) begin : g_up
        assign beat_up = live_i[C+NSEG] && gf_pkg::outranks(key_i[C+NSEG], C + NSEG, key_i[C], C);
      end else begin : g_nup
        assign beat_up = 1'b0;
      end
      assign ghost_o[C] = live_i[C] && (beat_dn || beat_up);
    end
  end
endmodule

// File: rtl/gf_rank_select.sv
module gf_rank_select #(
  parameter int NCELL = 48,
  parameter int NOUT  = 4,
  localparam int IW   = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic                      live_i [NCELL],
  input  gf_pkg::rank_key_t         key_i  [NCELL],
  output logic [NOUT-1:0]           sel_vld_o,
  output logic [IW-1:0]             sel_idx_o [NOUT]
);
  always_comb begin
    logic [NCELL-1:0] taken;
    taken = '0;
    for (int k = 0; k < NOUT; k++) begin
      int   best;
      logic found;
      best  = 0;
      found = 1'b0;
      for (int c = 0; c < NCELL; c++) begin
        if (live_i[c] && !taken[c] &&
            (!found || gf_pkg::outranks(key_i[c], c, key_i[best], best))) begin
          best  = c;
          found = 1'b1;
        end
      end
      if (found) taken[best] = 1'b1;
      sel_vld_o[k] = found;
      sel_idx_o[k] = found ? IW'(best) : '0;
    end
  end
endmodule

// File: rtl/gf_ghost_filter.sv
module gf_ghost_filter #(
  parameter int NSEG = 12,
  parameter int NTWR = 4,
  parameter int QW   = 2,
  parameter int PW   = 5,
  parameter int NOUT = 4,
  localparam int NCELL = NSEG * NTWR,
  localparam int TW    = (NTWR > 1) ? $clog2(NTWR) : 1,
  localparam int SW    = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int IW    = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCELL-1:0]      cand_vld_i,
  input  logic [NCELL*QW-1:0]   cand_q_i,
  input  logic [NCELL*PW-1:0]   cand_pt_i,
  output logic [NOUT-1:0]       best_vld_o,
  output logic [NOUT*QW-1:0]    best_q_o,
  output logic [NOUT*PW-1:0]    best_pt_o,
  output logic [NOUT*TW-1:0]    best_twr_o,
  output logic [NOUT*SW-1:0]    best_seg_o,
  output logic [NCELL-1:0]      edge_ghost_o
);
  function automatic logic [NCELL-1:0] rim_map();
    logic [NCELL-1:0] m;
    for (int t = 0; t < NTWR; t++)
      for (int s = 0; s < NSEG; s++)
        m[t*NSEG+s] = (s == 0) || (s == NSEG - 1) || (t == 0) || (t == NTWR - 1);
    return m;
  endfunction
  localparam logic [NCELL-1:0] RIM = rim_map();

  // ---- stage A: combinational two-pass suppression on the raw grid ----
  gf_pkg::rank_key_t in_key    [NCELL];
  logic              in_vld    [NCELL];
  logic              ghost_phi [NCELL];
  logic              live_phi  [NCELL];
  logic              ghost_eta [NCELL];
  logic              live_fin  [NCELL];
  logic [NCELL-1:0]  rim_ghost;

  for (genvar c = 0; c < NCELL; c++) begin : g_unpack
    assign in_vld[c]    = cand_vld_i[c];
    assign in_key[c]    = gf_pkg::make_key(8'(cand_q_i[c*QW +: QW]), 8'(cand_pt_i[c*PW +: PW]));
    assign live_phi[c]  = in_vld[c] && !ghost_phi[c];
    assign live_fin[c]  = live_phi[c] && !ghost_eta[c];
    assign rim_ghost[c] = RIM[c] && in_vld[c] && (ghost_phi[c] || ghost_eta[c]);
  end

  gf_phi_stage #(.NSEG(NSEG), .NTWR(NTWR)) u_phi (
    .vld_i(in_vld), .key_i(in_key), .ghost_o(ghost_phi)
  );

  gf_eta_stage #(.NSEG(NSEG), .NTWR(NTWR)) u_eta (
    .live_i(live_phi), .key_i(in_key), .ghost_o(ghost_eta)
  );

  // ---- pipeline register between suppression and selection ----
  logic [NCELL-1:0]  live_q;
  logic [QW-1:0]     q_q    [NCELL];
  logic [PW-1:0]     pt_q   [NCELL];
  logic [NCELL-1:0]  rim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      rim_q  <= '0;
      for (int c = 0; c < NCELL; c++) begin
        q_q[c]  <= '0;
        pt_q[c] <= '0;
      end
    end else begin
      rim_q <= rim_ghost;
      for (int c = 0; c < NCELL; c++) begin
        live_q[c] <= live_fin[c];
        q_q[c]    <= cand_q_i[c*QW +: QW];
        pt_q[c]   <= cand_pt_i[c*PW +: PW];
      end
    end
  end

  // ---- stage B: rank selection ----
  gf_pkg::rank_key_t sel_key  [NCELL];
  logic              sel_live [NCELL];
  logic [NOUT-1:0]   sel_vld;
  logic [IW-1:0]     sel_idx  [NOUT];

  for (genvar c = 0; c < NCELL; c++) begin : g_selin
    assign sel_key[c]  = gf_pkg::make_key(8'(q_q[c]), 8'(pt_q[c]));
    assign sel_live[c] = live_q[c];
  end

  gf_rank_select #(.NCELL(NCELL), .NOUT(NOUT)) u_sel (
    .live_i(sel_live), .key_i(sel_key), .sel_vld_o(sel_vld), .sel_idx_o(sel_idx)
  );

  logic [NOUT*QW-1:0] nxt_q;
  logic [NOUT*PW-1:0] nxt_pt;
  logic [NOUT*TW-1:0] nxt_twr;
  logic [NOUT*SW-1:0] nxt_seg;

  for (genvar k = 0; k < NOUT; k++) begin : g_slot
    assign nxt_q[k*QW +: QW]   = sel_vld[k] ? q_q[sel_idx[k]]  : '0;
    assign nxt_pt[k*PW +: PW]  = sel_vld[k] ? pt_q[sel_idx[k]] : '0;
    assign nxt_twr[k*TW +: TW] = sel_vld[k] ? TW'(int'(sel_idx[k]) / NSEG) : '0;
    assign nxt_seg[k*SW +: SW] = sel_vld[k] ? SW'(int'(sel_idx[k]) % NSEG) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_vld_o   <= '0;
      best_q_o     <= '0;
      best_pt_o    <= '0;
      best_twr_o   <= '0;
      best_seg_o   <= '0;
      edge_ghost_o <= '0;
    end else begin
      best_vld_o   <= sel_vld;
      best_q_o     <= nxt_q;
      best_pt_o    <= nxt_pt;
      best_twr_o   <= nxt_twr;
      best_seg_o   <= nxt_seg;
      edge_ghost_o <= rim_q;
    end
  end
endmodule

// File: rtl/gf_ghost_filter_chk.sv
module gf_ghost_filter_chk #(
  parameter int NSEG = 12,
  parameter int NTWR = 4,
  parameter int QW   = 2,
  parameter int PW   = 5,
  parameter int NOUT = 4,
  localparam int NCELL = NSEG * NTWR,
  localparam int TW    = (NTWR > 1) ? $clog2(NTWR) : 1,
  localparam int SW    = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCELL-1:0]   cand_vld_i,
  input logic [NOUT-1:0]    best_vld_o,
  input logic [NOUT*QW-1:0] best_q_o,
  input logic [NOUT*PW-1:0] best_pt_o,
  input logic [NOUT*TW-1:0] best_twr_o,
  input logic [NOUT*SW-1:0] best_seg_o,
  input logic [NCELL-1:0]   edge_ghost_o
);
  function automatic logic [NCELL-1:0] interior_map();
    logic [NCELL-1:0] m;
    for (int t = 0; t < NTWR; t++)
      for (int s = 0; s < NSEG; s++)
        m[t*NSEG+s] = (s > 0) && (s < NSEG - 1) && (t > 0) && (t < NTWR - 1);
    return m;
  endfunction
  localparam logic [NCELL-1:0] INNER = interior_map();

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && $past(cand_vld_i, 2) == '0) |-> best_vld_o == '0);

  p_rim_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (edge_ghost_o & ~$past(cand_vld_i, 2)) == '0);

  p_rim_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ghost_o & INNER) == '0);

  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> $countones(best_vld_o) <= $countones($past(cand_vld_i, 2)));

  for (genvar k = 0; k < NOUT; k++) begin : g_slot
    p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !best_vld_o[k] |-> (best_q_o[k*QW +: QW] == '0 && best_pt_o[k*PW +: PW] == '0 &&
                          best_twr_o[k*TW +: TW] == '0 && best_seg_o[k*SW +: SW] == '0));
    if (k < NOUT - 1) begin : g_pair
      logic [QW+PW-1:0] ka, kb;
      int ia, ib;
      assign ka = {best_q_o[k*QW +: QW], best_pt_o[k*PW +: PW]};
      assign kb = {best_q_o[(k+1)*QW +: QW], best_pt_o[(k+1)*PW +: PW]};
      assign ia = int'(best_twr_o[k*TW +: TW]) * NSEG + int'(best_seg_o[k*SW +: SW]);
      assign ib = int'(best_twr_o[(k+1)*TW +: TW]) * NSEG + int'(best_seg_o[(k+1)*SW +: SW]);
      p_pack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !best_vld_o[k] |-> !best_vld_o[k+1]);
      p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        best_vld_o[k+1] |-> (ka > kb || (ka == kb && ia < ib)));
    end
  end
endmodule

bind gf_ghost_filter gf_ghost_filter_chk #(
  .NSEG(NSEG), .NTWR(NTWR), .QW(QW), .PW(PW), .NOUT(NOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_vld_i(cand_vld_i),
  .best_vld_o(best_vld_o), .best_q_o(best_q_o), .best_pt_o(best_pt_o),
  .best_twr_o(best_twr_o), .best_seg_o(best_seg_o), .edge_ghost_o(edge_ghost_o)
);

// File: tb/gf_ghost_filter_test.sv
`timescale 1ns/1ps
module gf_ghost_filter_test;
  localparam int NSEG = 12, NTWR = 4, QW = 2, PW = 5, NOUT = 4;
  localparam int NCELL = NSEG * NTWR;
  localparam int TW = 2, SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCELL-1:0]    cand_vld = '0;
  logic [NCELL*QW-1:0] cand_q = '0;
  logic [NCELL*PW-1:0] cand_pt = '0;
  logic [NOUT-1:0]     best_vld;
  logic [NOUT*QW-1:0]  best_q;
  logic [NOUT*PW-1:0]  best_pt;
  logic [NOUT*TW-1:0]  best_twr;
  logic [NOUT*SW-1:0]  best_seg;
  logic [NCELL-1:0]    edge_ghost;

  always #4 clk = ~clk;

  gf_ghost_filter #(.NSEG(NSEG), .NTWR(NTWR), .QW(QW), .PW(PW), .NOUT(NOUT)) uut (
    .clk(clk), .rst_n(rst_n), .cand_vld_i(cand_vld), .cand_q_i(cand_q), .cand_pt_i(cand_pt),
    .best_vld_o(best_vld), .best_q_o(best_q), .best_pt_o(best_pt),
    .best_twr_o(best_twr), .best_seg_o(best_seg), .edge_ghost_o(edge_ghost)
  );

  int n_chk = 0, n_err = 0;
  int m_v [NCELL], m_q [NCELL], m_p [NCELL];

  function automatic void clear_grid();
    for (int c = 0; c < NCELL; c++) begin m_v[c] = 0; m_q[c] = 0; m_p[c] = 0; end
  endfunction

  function automatic void put(int t, int s, int q, int p);
    m_v[t*NSEG+s] = 1; m_q[t*NSEG+s] = q; m_p[t*NSEG+s] = p;
  endfunction

  // a ranks above b: bigger quality, then bigger code, then smaller flat index
  function automatic bit wins(int a, int b);
    if (m_q[a] != m_q[b]) return m_q[a] > m_q[b];
    if (m_p[a] != m_p[b]) return m_p[a] > m_p[b];
    return a < b;
  endfunction

  task automatic drive();
    for (int c = 0; c < NCELL; c++) begin
      cand_vld[c] = m_v[c][0];
      cand_q[c*QW +: QW] = m_q[c][QW-1:0];
      cand_pt[c*PW +: PW] = m_p[c][PW-1:0];
    end
  endtask

  task automatic expect_out(string tag, output logic [NOUT-1:0] ev, output logic [NOUT*QW-1:0] eq,
                            output logic [NOUT*PW-1:0] ep, output logic [NOUT*TW-1:0] et,
                            output logic [NOUT*SW-1:0] es, output logic [NCELL-1:0] eg);
    bit g1 [NCELL], live1 [NCELL], dead [NCELL];
    ev = '0; eq = '0; ep = '0; et = '0; es = '0; eg = '0;
    for (int c = 0; c < NCELL; c++) begin
      int s = c % NSEG;
      g1[c] = 0;
      if (m_v[c] != 0) begin
        if (s > 0 && m_v[c-1] != 0 && wins(c-1, c)) g1[c] = 1;
        if (s < NSEG-1 && m_v[c+1] != 0 && wins(c+1, c)) g1[c] = 1;
      end
      live1[c] = (m_v[c] != 0) && !g1[c];
    end
    for (int c = 0; c < NCELL; c++) begin
      int t = c / NSEG;
      bit g2 = 0;
      if (live1[c]) begin
        if (t > 0 && live1[c-NSEG] && wins(c-NSEG, c)) g2 = 1;
        if (t < NTWR-1 && live1[c+NSEG] && wins(c+NSEG, c)) g2 = 1;
      end
      dead[c] = g1[c] || g2;
      if (m_v[c] != 0 && dead[c] &&
          (c % NSEG == 0 || c % NSEG == NSEG-1 || t == 0 || t == NTWR-1)) eg[c] = 1'b1;
    end
    for (int c = 0; c < NCELL; c++) begin
      if (m_v[c] != 0 && !dead[c]) begin
        int r = 0;
        for (int d = 0; d < NCELL; d++)
          if (d != c && m_v[d] != 0 && !dead[d] && wins(d, c)) r++;
        if (r < NOUT) begin
          ev[r] = 1'b1;
          eq[r*QW +: QW] = m_q[c][QW-1:0];
          ep[r*PW +: PW] = m_p[c][PW-1:0];
          et[r*TW +: TW] = TW'(c / NSEG);
          es[r*SW +: SW] = SW'(c % NSEG);
        end
      end
    end
  endtask

  task automatic compare(string tag);
    logic [NOUT-1:0] ev; logic [NOUT*QW-1:0] eq; logic [NOUT*PW-1:0] ep;
    logic [NOUT*TW-1:0] et; logic [NOUT*SW-1:0] es; logic [NCELL-1:0] eg;
    expect_out(tag, ev, eq, ep, et, es, eg);
    n_chk++;
    if ({best_vld, best_q, best_pt, best_twr, best_seg} !== {ev, eq, ep, et, es}) begin
      n_err++;
      $display("FAIL %s slots: actual vld=%b q=%h pt=%h twr=%h seg=%h expected vld=%b q=%h pt=%h twr=%h seg=%h",
               tag, best_vld, best_q, best_pt, best_twr, best_seg, ev, eq, ep, et, es);
    end
    n_chk++;
    if (edge_ghost !== eg) begin
      n_err++;
      $display("FAIL R9 (%s) rim mask: actual=%h expected=%h", tag, edge_ghost, eg);
    end
  endtask

  // apply grid before an edge, check just after the second edge (R10 latency)
  task automatic run(string tag);
    @(negedge clk); drive();
    @(posedge clk); @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1: outputs held at zero during reset even with a busy grid
    clear_grid(); put(1, 3, 3, 9); put(2, 7, 1, 4); drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if ({best_vld, best_q, best_pt, best_twr, best_seg, edge_ghost} !== '0) begin
      n_err++;
      $display("FAIL R1 reset outputs: actual vld=%b rim=%h expected all zero", best_vld, edge_ghost);
    end
    clear_grid(); drive();
    rst_n = 1'b1;

    clear_grid(); run("R8 empty grid");
    clear_grid(); put(2, 6, 1, 3); run("R8 single survivor");
    clear_grid(); put(1, 5, 3, 2); put(1, 6, 1, 31); run("R2 higher quality wins");
    clear_grid(); put(2, 4, 2, 10); put(2, 5, 2, 20); run("R3 equal quality, larger code");
    clear_grid(); put(1, 8, 2, 7); put(1, 9, 2, 7); run("R4 full tie lower index");
    clear_grid(); put(1, 5, 2, 9); put(2, 5, 3, 1); run("R5 tower neighbour");
    clear_grid(); put(1, 4, 3, 0); put(1, 5, 2, 0); put(2, 5, 1, 0); run("R5 phi ghost ignored in eta pass");
    clear_grid(); put(0, 0, 0, 1); put(0, 11, 3, 1); put(0, 3, 1, 1); put(3, 3, 3, 1); run("R6 no wrap");
    clear_grid(); put(1, 5, 0, 0); m_v[1*NSEG+4] = 0; m_q[1*NSEG+4] = 3; m_p[1*NSEG+4] = 31;
    m_q[2*NSEG+5] = 3; m_p[2*NSEG+5] = 31; run("R11 invalid neighbour inert");
    clear_grid(); put(0, 4, 3, 5); put(0, 5, 1, 5); put(1, 8, 3, 5); put(1, 9, 1, 5); run("R9 rim vs interior ghost");
    clear_grid(); put(0, 1, 1, 3); put(1, 3, 3, 2); put(2, 6, 3, 9); put(3, 9, 2, 30);
    put(0, 8, 0, 31); put(3, 1, 3, 2); run("R7 top four ordered");

    // R10: only one edge after a new grid, the old (empty) result remains
    clear_grid(); run("R10 prepare empty");
    put(1, 2, 2, 2);
    @(negedge clk); drive(); @(posedge clk); @(negedge clk);
    n_chk++;
    if (best_vld !== '0) begin
      n_err++;
      $display("FAIL R10 after one edge: actual vld=%b expected 0000", best_vld);
    end
    @(posedge clk); @(negedge clk); compare("R10 after two edges");

    // R2 R3 R4 R5: every quality pair over several codes, both neighbour directions
    for (int dir = 0; dir < 2; dir++)
      for (int qa = 0; qa < 4; qa++)
        for (int qb = 0; qb < 4; qb++)
          for (int pa = 0; pa < 3; pa++)
            for (int pb = 0; pb < 3; pb++) begin
              clear_grid();
              put(1, 5, qa, pa * 15);
              if (dir == 0) put(1, 6, qb, pb * 15); else put(2, 5, qb, pb * 15);
              run(dir == 0 ? "R2 R3 R4 phi pair sweep" : "R5 eta pair sweep");
            end

    // R7 R8 R9: random grids of growing density
    for (int n = 0; n < 400; n++) begin
      int dens = 5 + (n % 8) * 12;
      clear_grid();
      for (int c = 0; c < NCELL; c++)
        if ($urandom_range(99) < dens) begin
          m_v[c] = 1; m_q[c] = $urandom_range(3); m_p[c] = $urandom_range(31);
        end
      run("R7 random grid");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule